// File: doc/BRIEF.md
# Presettable Synchronous Up/Down Counter

A four-bit reversible counter whose bits all switch together on the rising clock edge. One parameter selects the modulus: a binary mode that spans 0 to 15, or a decade mode that spans 0 to 9. The count advances only while the active-low enable is held. A direction input selects increment or decrement. An active-low load input copies the data word into the count at once. It does not wait for a clock edge, and it wins over counting.

Two outputs support chaining of stages. `at_limit` is high while the count sits on the terminal value for the current direction: the top value when counting up, zero when counting down. `ripple_n` pulses low during the low half of the clock when the stage is at its limit and enabled. Several stages are chained by connecting each stage's `ripple_n` to the next stage's clock and sharing enable and direction. The rising edge of `ripple_n` then falls on the same clock edge that wraps the lower stage.

Top module: `updown_counter`

## Requirements
- R1: With load released and enable low, the count changes by exactly one at each rising clock edge and never between edges.
- R2: With enable high, the count keeps its value across clock edges.
- R3: Direction low makes the count increment. Direction high makes it decrement.
- R4: Load low sets the count to the data word immediately, without a clock edge. The data word is held through clock edges while load stays low, whatever enable and direction are.
- R5: In binary mode (DECADE=0) the count wraps from 15 to 0 going up and from 0 to 15 going down.
- R6: In decade mode (DECADE=1) the count wraps from 9 to 0 going up and from 0 to 9 going down.
- R7: `at_limit` is high exactly when direction is up and the count equals the top value (15 binary, 9 decade), or when direction is down and the count is 0.
- R8: `ripple_n` is low only while the clock is low, `at_limit` is high and enable is low. It is high at all other times.
- R9: Enable and direction may change while the clock is high or low. The new values apply at the next rising edge.
- R10: `at_limit` follows a change of direction without any clock edge.
- R11: In decade mode, a loaded count of 10 to 15 goes to 0 on an up-count and to one less on a down-count, and `at_limit` stays low there.
- R12: Two stages chained through `ripple_n` into the upper stage's clock behave as one two-digit counter (0–255 binary, 0–99 decade) in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock, rising edge active |
| load_n | input | 1 | Active-low asynchronous parallel load |
| cnt_en_n | input | 1 | Active-low count enable |
| down | input | 1 | Direction: 0 counts up, 1 counts down |
| ld_data | input | 4 | Value copied into the count during load |
| count | output | 4 | Present count |
| at_limit | output | 1 | High at the terminal value for the current direction |
| ripple_n | output | 1 | Active-low cascade pulse in the clock-low phase |

## Verification
A table of stimulus rows drives a binary and a decade instance side by side. The rows cover long up and down runs, which separate the two wrap points; a hold row, which separates enable from direction; and loads of 9, 12 and 15, which separate in-range decade behaviour from the out-of-range recovery path. Every step samples `ripple_n` in both clock phases, which separates a correctly phase-gated pulse from one that follows only `at_limit`. Chained binary and decade pairs run from loads such as 97, 99 and 01, so carries and borrows across the stage boundary are checked against a plain two-digit model. Directed tests then change enable and direction during the clock-low phase and flip direction with no clock edge.

// File: rtl/updown_pkg.sv
`timescale 1ns/1ps
package updown_pkg;
    localparam int CNT_W = 4;

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    function automatic logic [CNT_W-1:0] top_value(input bit decade);
        return decade ? CNT_W'(9) : {CNT_W{1'b1}};
    endfunction
endpackage

// File: rtl/updown_step.sv
`timescale 1ns/1ps
module updown_step
    import updown_pkg::*;
#(
    parameter bit DECADE = 1'b0
) (
    input  logic [CNT_W-1:0] cur,
    input  logic             down,
    output logic [CNT_W-1:0] nxt
);
    localparam logic [CNT_W-1:0] TOP = top_value(DECADE);

    always_comb begin
        if (!down) begin
            // values at or above the top (decade recovery) fold to zero
            nxt = (cur >= TOP) ? '0 : cur + 1'b1;
        end else begin
            nxt = (cur == '0) ? TOP : cur - 1'b1;
        end
    end
endmodule

// File: rtl/updown_limit.sv
`timescale 1ns/1ps
module updown_limit
    import updown_pkg::*;
#(
    parameter bit DECADE = 1'b0
) (
    input  logic [CNT_W-1:0] cur,
    input  logic             down,
    output logic             hit
);
    localparam logic [CNT_W-1:0] TOP = top_value(DECADE);

    always_comb begin
        hit = down ? (cur == '0) : (cur == TOP);
    end
endmodule

// File: rtl/updown_counter.sv
`timescale 1ns/1ps
module updown_counter
    import updown_pkg::*;
#(
    parameter bit DECADE = 1'b0
) (
    input  logic             clk,
    input  logic             load_n,
    input  logic             cnt_en_n,
    input  logic             down,
    input  logic [CNT_W-1:0] ld_data,
    output logic [CNT_W-1:0] count,
    output logic             at_limit,
    output logic             ripple_n
);
    localparam logic [CNT_W-1:0] TOP = top_value(DECADE);

    cnt_state_t       state_d, state_q;
    logic [CNT_W-1:0] step_val;

    updown_step #(.DECADE(DECADE)) u_step (
        .cur  (state_q.count),
        .down (down),
        .nxt  (step_val)
    );

    updown_limit #(.DECADE(DECADE)) u_limit (
        .cur  (state_q.count),
        .down (down),
        .hit  (at_limit)
    );

    always_comb begin
        state_d = state_q;
        if (!cnt_en_n) begin
            state_d.count = step_val;
        end
    end

    // load dominates both the edge and the level of the clock
    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n) begin
            state_q.count <= ld_data;
        end else begin
            state_q <= state_d;
        end
    end

    assign count    = state_q.count;
    assign ripple_n = ~(at_limit & ~cnt_en_n & ~clk);

    // check-only flag: marks the first edge after an asynchronous load
    logic ld_mark_q;
    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n) begin
            ld_mark_q <= 1'b1;
        end else begin
            ld_mark_q <= 1'b0;
        end
    end

    p_step_up_r1: assert property (@(posedge clk) disable iff (!load_n || ld_mark_q)
        (!cnt_en_n && !down && count < TOP) |=> count == $past(count) + 4'd1);

    p_hold_r2: assert property (@(posedge clk) disable iff (!load_n || ld_mark_q)
        cnt_en_n |=> $stable(count));

    p_step_down_r3: assert property (@(posedge clk) disable iff (!load_n || ld_mark_q)
        (!cnt_en_n && down && count != '0) |=> count == $past(count) - 4'd1);

    p_load_r4: assert property (@(posedge clk)
        !load_n |-> count == ld_data);

    p_ripple_r8: assert property (@(posedge clk) disable iff (!load_n)
        !ripple_n |-> (at_limit && !cnt_en_n));

    generate
        if (DECADE) begin : g_dec_chk
            p_wrap_up_r6: assert property (@(posedge clk) disable iff (!load_n || ld_mark_q)
                (!cnt_en_n && !down && count == 4'd9) |=> count == 4'd0);
            p_wrap_down_r6: assert property (@(posedge clk) disable iff (!load_n || ld_mark_q)
                (!cnt_en_n && down && count == 4'd0) |=> count == 4'd9);
            p_range_r11: assert property (@(posedge clk) disable iff (!load_n || ld_mark_q)
                (!cnt_en_n && !down && count > 4'd9) |=> count == 4'd0);
        end else begin : g_bin_chk
            p_wrap_up_r5: assert property (@(posedge clk) disable iff (!load_n || ld_mark_q)
                (!cnt_en_n && !down && count == 4'd15) |=> count == 4'd0);
            p_wrap_down_r5: assert property (@(posedge clk) disable iff (!load_n || ld_mark_q)
                (!cnt_en_n && down && count == 4'd0) |=> count == 4'd15);
        end
    endgenerate
endmodule

// File: tb/updown_counter_tb.sv
`timescale 1ns/1ps
module updown_counter_tb_top;
    logic       clk = 1'b0;
    logic       load_n = 1'b1;
    logic       en_n = 1'b1;
    logic       dn = 1'b0;
    logic [3:0] d4 = 4'd3;
    logic [7:0] c8 = 8'h42;

    logic [3:0] cnt_b, cnt_d, cbl, cbh, cdl, cdh;
    logic       lim_b, lim_d, rip_b, rip_d;
    logic       cbl_lim, cbh_lim, cbl_rip, cbh_rip;
    logic       cdl_lim, cdh_lim, cdl_rip, cdh_rip;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    updown_counter #(.DECADE(1'b0)) dut_i (
        .clk(clk), .load_n(load_n), .cnt_en_n(en_n), .down(dn), .ld_data(d4),
        .count(cnt_b), .at_limit(lim_b), .ripple_n(rip_b));
    updown_counter #(.DECADE(1'b1)) dut_dec (
        .clk(clk), .load_n(load_n), .cnt_en_n(en_n), .down(dn), .ld_data(d4),
        .count(cnt_d), .at_limit(lim_d), .ripple_n(rip_d));

    // R12 chained pairs: lower stage ripple_n clocks the upper stage
    updown_counter #(.DECADE(1'b0)) cas_bin_lo (
        .clk(clk), .load_n(load_n), .cnt_en_n(en_n), .down(dn), .ld_data(c8[3:0]),
        .count(cbl), .at_limit(cbl_lim), .ripple_n(cbl_rip));
    updown_counter #(.DECADE(1'b0)) cas_bin_hi (
        .clk(cbl_rip), .load_n(load_n), .cnt_en_n(en_n), .down(dn), .ld_data(c8[7:4]),
        .count(cbh), .at_limit(cbh_lim), .ripple_n(cbh_rip));
    updown_counter #(.DECADE(1'b1)) cas_dec_lo (
        .clk(clk), .load_n(load_n), .cnt_en_n(en_n), .down(dn), .ld_data(c8[3:0]),
        .count(cdl), .at_limit(cdl_lim), .ripple_n(cdl_rip));
    updown_counter #(.DECADE(1'b1)) cas_dec_hi (
        .clk(cdl_rip), .load_n(load_n), .cnt_en_n(en_n), .down(dn), .ld_data(c8[7:4]),
        .count(cdh), .at_limit(cdh_lim), .ripple_n(cdh_rip));

    logic [3:0] mb, md;
    logic [7:0] cb;
    int         cdv;

    function automatic logic [3:0] nxt(input logic [3:0] c, input logic d, input bit dec);
        logic [3:0] m;
        m = dec ? 4'd9 : 4'd15;
        if (!d) return (c >= m) ? 4'd0 : c + 4'd1;
        return (c == 4'd0) ? m : c - 4'd1;
    endfunction

    function automatic logic term(input logic [3:0] c, input logic d, input bit dec);
        return d ? (c == 4'd0) : (c == (dec ? 4'd9 : 4'd15));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_cascade(input string req);
        logic [7:0] bcd;
        bcd = {4'(cdv / 10), 4'(cdv % 10)};
        chk({cbh, cbl} == cb, req, {cbh, cbl}, cb);
        chk({cdh, cdl} == bcd, req, {cdh, cdl}, bcd);
    endtask

    task automatic load_all(input logic [3:0] dv, input logic [7:0] cv);
        @(posedge clk); #1;
        d4 = dv; c8 = cv; load_n = 1'b0;
        #0.5;
        chk(cnt_b == dv, "R4 async load binary", cnt_b, dv);
        chk(cnt_d == dv, "R4 async load decade", cnt_d, dv);
        mb = dv; md = dv; cb = cv;
        cdv = int'(cv[7:4]) * 10 + int'(cv[3:0]);
        chk_cascade("R4 R12 load pair");
        #0.5 load_n = 1'b1;
    endtask

    task automatic step();
        @(posedge clk); #1;
        if (!en_n) begin
            mb = nxt(mb, dn, 1'b0);
            md = nxt(md, dn, 1'b1);
            cb = dn ? cb - 8'd1 : cb + 8'd1;
            cdv = dn ? (cdv + 99) % 100 : (cdv + 1) % 100;
        end
        chk(cnt_b == mb, "R1 R2 R3 R5 binary count", cnt_b, mb);
        chk(cnt_d == md, "R1 R2 R3 R6 R11 decade count", cnt_d, md);
        chk(lim_b == term(mb, dn, 1'b0), "R7 binary limit", lim_b, term(mb, dn, 1'b0));
        chk(lim_d == term(md, dn, 1'b1), "R7 R11 decade limit", lim_d, term(md, dn, 1'b1));
        chk(rip_b == 1'b1 && rip_d == 1'b1, "R8 ripple high in clock-high phase", {rip_b, rip_d}, 3);
        chk_cascade("R12 chained pair");
        @(negedge clk); #1;
        chk(rip_b == !(term(mb, dn, 1'b0) && !en_n), "R8 binary ripple low phase",
            rip_b, !(term(mb, dn, 1'b0) && !en_n));
        chk(rip_d == !(term(md, dn, 1'b1) && !en_n), "R8 decade ripple low phase",
            rip_d, !(term(md, dn, 1'b1) && !en_n));
    endtask

    // {load, data, pair data, enable_n, down, steps}
    localparam int NV = 7;
    localparam logic [22:0] VECS [NV] = '{
        {1'b1, 4'd0,  8'h97, 1'b0, 1'b0, 8'd20},
        {1'b0, 4'd0,  8'h00, 1'b1, 1'b0, 8'd3},
        {1'b0, 4'd0,  8'h00, 1'b0, 1'b1, 8'd25},
        {1'b1, 4'd12, 8'h02, 1'b0, 1'b0, 8'd2},
        {1'b1, 4'd12, 8'h01, 1'b0, 1'b1, 8'd4},
        {1'b1, 4'd9,  8'h99, 1'b0, 1'b0, 8'd3},
        {1'b1, 4'd15, 8'h10, 1'b0, 1'b1, 8'd3}
    };

    initial begin
        #1 load_n = 1'b0;
        en_n = 1'b0;
        #0.5;
        chk(cnt_b == 4'd3, "R4 reset-state load binary", cnt_b, 3);
        chk(cnt_d == 4'd3, "R4 reset-state load decade", cnt_d, 3);
        @(posedge clk); @(posedge clk); #1;
        chk(cnt_b == 4'd3 && cnt_d == 4'd3, "R4 load priority over counting", cnt_b, 3);
        chk({cbh, cbl} == 8'h42, "R4 R12 pair load", {cbh, cbl}, 8'h42);
        load_n = 1'b1;
        mb = 4'd3; md = 4'd3; cb = 8'h42; cdv = 42;

        for (int i = 0; i < NV; i++) begin
            if (VECS[i][22]) begin
                load_all(VECS[i][21:18], VECS[i][17:10]);
                if (VECS[i][21:18] > 4'd9)
                    chk(lim_d == 1'b0, "R11 limit low out of range", lim_d, 0);
            end
            en_n = VECS[i][9];
            dn   = VECS[i][8];
            for (int s = 0; s < int'(VECS[i][7:0]); s++) step();
        end

        // R10: direction flip without a clock edge
        en_n = 1'b1; dn = 1'b0;
        load_all(4'd0, 8'h00);
        chk(lim_b == 1'b0, "R10 limit low at 0 counting up", lim_b, 0);
        dn = 1'b1; #0.5;
        chk(lim_b == 1'b1, "R10 limit follows direction", lim_b, 1);
        dn = 1'b0; #0.5;
        chk(lim_b == 1'b0, "R10 limit follows direction back", lim_b, 0);

        // R9: enable and direction changed in the clock-low phase
        @(negedge clk); #1;
        en_n = 1'b0; dn = 1'b0;
        step();
        chk(cnt_b == 4'd1, "R9 enable taken in low phase", cnt_b, 1);
        dn = 1'b1;
        step();
        chk(cnt_b == 4'd0, "R9 direction taken in low phase", cnt_b, 0);
        step();
        chk(cnt_b == 4'd15 && cnt_d == 4'd9, "R5 R6 down wrap", cnt_b, 15);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule